// File: doc/BRIEF.md
# Token-Ring Depth Expansion for Cascaded FIFO Slices

This block joins several identical FIFO slices into one deeper FIFO. Each slice carries two small token state machines: one for write ownership and one for read ownership. Only the slice that holds the write token accepts a write, and only the slice that holds the read token supplies read data. The wrapper presents a single write port, a single read port and global flags.

A slice gives up a token when it accesses its last physical location. At that point it fires a one-cycle hand-off pulse on its write or read expansion output. The expansion outputs of each slice drive the expansion inputs of the next slice, and the last slice loops back to the first, so both tokens travel round a closed ring. A first-load strap picks the one slice that holds both tokens after reset. Each slice's pointers wrap to zero after its last location, so the same slice can take the token again on the next lap.

Each token state machine has two states. `TOK_WAIT` means the slice does not own the token. `TOK_HOLD` means it does. The reset state is `TOK_HOLD` when the first-load strap is high and `TOK_WAIT` otherwise. There are two transitions:
- `TAKE` (`TOK_WAIT` to `TOK_HOLD`): the expansion input pulse is high at a rising clock edge.
- `GIVE` (`TOK_HOLD` to `TOK_WAIT`): the slice's own hand-off pulse is high and no incoming pulse arrives in the same cycle. In a one-slice ring the pulse returns to the slice itself, so it keeps the token.

The whole block runs on one clock.

Top module: `xpn_fifo_ring`

## Requirements
- R1: After reset `empty` is 1, `full` is 0, and the slice strapped as first load holds both tokens.
- R2: Words leave `rd_data` in exactly the order they were accepted, across slice boundaries.
- R3: Starting from empty with no reads, `full` rises after exactly NUM_SLICES*SLICE_DEPTH accepted writes, and not before.
- R4: A write presented while `full` is 1 is ignored. The next words read are unchanged, and `full` stays 1 if no read happens.
- R5: A read presented while `empty` is 1 is ignored. `empty` stays 1 if no write happens, and later data is not shifted.
- R6: A read and a write in the same cycle both take effect whenever the FIFO is neither empty nor full.
- R7: After more than NUM_SLICES*SLICE_DEPTH words have passed through, both tokens have completed a lap of the ring and data order is still preserved.
- R8: Exactly one slice holds the write token and exactly one holds the read token at every clock. A token moves only in a cycle in which a hand-off pulse fires.
- R9: While `empty` is 0, `rd_data` shows the oldest unread word before the read is issued, with no read latency.
- R10: At most one write hand-off pulse and at most one read hand-off pulse fire in any cycle. Each pulse moves its token to the next slice at that clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by the write and read sides |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write request, honoured when not full |
| wr_data | input | DATA_W | Word to write |
| rd_en | input | 1 | Read request, honoured when not empty |
| rd_data | output | DATA_W | Oldest unread word (show-ahead) |
| empty | output | 1 | High when no word is stored |
| full | output | 1 | High when every slice location holds an unread word |

## Verification
The hardest case to reach is the point where both tokens sit on the same slice again after a full lap. In that state one slice holds both the newest and the oldest words, and its hand-off pulses for writing and reading can fire close together. The stimulus first fills the ring to full and then partly drains it. It then runs a long stretch of simultaneous reads and writes, which moves both tokens round several laps at a fixed distance apart. A pseudo-random mix of requests follows, which pushes the ring through repeated empty and full boundaries, including requests made while it is empty or full.

// File: rtl/xpn_pkg.sv
package xpn_pkg;
    typedef enum logic {
        TOK_WAIT = 1'b0,
        TOK_HOLD = 1'b1
    } tok_state_t;
endpackage

// File: rtl/xpn_token_fsm.sv
// Ownership state machine for one token (write or read) in one slice.
module xpn_token_fsm
    import xpn_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic first_load,
    input  logic pass_in,
    input  logic req,
    input  logic ok,
    input  logic at_last,
    output logic hold,
    output logic grant,
    output logic pass_out
);
    tok_state_t state_q, state_d;

    // State register; the strap picks the reset owner (R1)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= first_load ? TOK_HOLD : TOK_WAIT;
        else        state_q <= state_d;
    end

    // Transitions TAKE and GIVE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TOK_WAIT: if (pass_in)              state_d = TOK_HOLD;
            TOK_HOLD: if (pass_out && !pass_in) state_d = TOK_WAIT;
            default:                            state_d = TOK_WAIT;
        endcase
    end

    // Outputs: grant only to the owner, pulse on the last location (R10)
    always_comb begin
        hold     = (state_q == TOK_HOLD);
        grant    = hold && req && ok;
        pass_out = grant && at_last;
    end
endmodule

// File: rtl/xpn_slice_store.sv
// Simple storage model of one slice: array, wrapping pointers, occupancy.
module xpn_slice_store #(
    parameter int DEPTH  = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wgrant,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rgrant,
    output logic [DATA_W-1:0] rdata,
    output logic              w_at_last,
    output logic              r_at_last,
    output logic              empty,
    output logic              full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
    localparam logic [CW-1:0] CAPC = CW'(DEPTH);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PW-1:0]     wptr, rptr;
    logic [CW-1:0]     cnt;

    always_ff @(posedge clk) begin
        if (wgrant) mem[wptr] <= wdata;
    end

    // Pointers wrap to zero after the last location (R7)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr <= '0;
            rptr <= '0;
            cnt  <= '0;
        end else begin
            if (wgrant) wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
            if (rgrant) rptr <= (rptr == LAST) ? '0 : rptr + 1'b1;
            unique case ({wgrant, rgrant})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    always_comb begin
        rdata     = mem[rptr];
        w_at_last = (wptr == LAST);
        r_at_last = (rptr == LAST);
        empty     = (cnt == '0);
        full      = (cnt == CAPC);
    end
endmodule

// File: rtl/xpn_slice.sv
// One cascadable slice: storage plus write and read token machines.
module xpn_slice #(
    parameter int DEPTH  = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              first_load,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic              wx_in,
    input  logic              rx_in,
    output logic              wx_out,
    output logic              rx_out,
    output logic              wtok,
    output logic              rtok,
    output logic [DATA_W-1:0] q_gated,
    output logic              s_empty,
    output logic              s_full
);
    logic wgrant, rgrant, w_last, r_last;
    logic [DATA_W-1:0] q_raw;

    xpn_slice_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .wgrant(wgrant), .wdata(wr_data),
        .rgrant(rgrant), .rdata(q_raw),
        .w_at_last(w_last), .r_at_last(r_last),
        .empty(s_empty), .full(s_full)
    );

    // Write side: ignored unless this slice owns the write token (R4)
    xpn_token_fsm u_wtok (
        .clk(clk), .rst_n(rst_n), .first_load(first_load),
        .pass_in(wx_in), .req(wr_en), .ok(!s_full), .at_last(w_last),
        .hold(wtok), .grant(wgrant), .pass_out(wx_out)
    );

    // Read side: ignored unless this slice owns the read token (R5)
    xpn_token_fsm u_rtok (
        .clk(clk), .rst_n(rst_n), .first_load(first_load),
        .pass_in(rx_in), .req(rd_en), .ok(!s_empty), .at_last(r_last),
        .hold(rtok), .grant(rgrant), .pass_out(rx_out)
    );

    assign q_gated = q_raw & {DATA_W{rtok}};
endmodule

// File: rtl/xpn_fifo_ring.sv
// Wrapper: NUM_SLICES slices joined in a closed expansion ring.
module xpn_fifo_ring #(
    parameter int NUM_SLICES  = 3,
    parameter int SLICE_DEPTH = 4,
    parameter int DATA_W      = 8,
    parameter int FIRST_SLICE = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              empty,
    output logic              full
);
    logic [NUM_SLICES-1:0] wtok_vec, rtok_vec, wxo_vec, rxo_vec;
    logic [NUM_SLICES-1:0] sl_empty, sl_full;
    logic [DATA_W-1:0]     sl_q [NUM_SLICES];

    for (genvar i = 0; i < NUM_SLICES; i++) begin : g_slice
        localparam int PREV = (i + NUM_SLICES - 1) % NUM_SLICES;
        xpn_slice #(.DEPTH(SLICE_DEPTH), .DATA_W(DATA_W)) u_slice (
            .clk(clk), .rst_n(rst_n),
            .first_load(i == FIRST_SLICE),
            .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
            .wx_in(wxo_vec[PREV]), .rx_in(rxo_vec[PREV]),
            .wx_out(wxo_vec[i]), .rx_out(rxo_vec[i]),
            .wtok(wtok_vec[i]), .rtok(rtok_vec[i]),
            .q_gated(sl_q[i]),
            .s_empty(sl_empty[i]), .s_full(sl_full[i])
        );
    end

    // Global flags follow the token owners; data is an OR of gated outputs (R9)
    always_comb begin
        rd_data = '0;
        empty   = 1'b0;
        full    = 1'b0;
        for (int i = 0; i < NUM_SLICES; i++) begin
            rd_data = rd_data | sl_q[i];
            empty   = empty | (rtok_vec[i] & sl_empty[i]);
            full    = full  | (wtok_vec[i] & sl_full[i]);
        end
    end
endmodule

// File: rtl/xpn_ring_checker.sv
module xpn_ring_checker #(
    parameter int NUM = 3
) (
    input logic           clk,
    input logic           rst_n,
    input logic           wr_en,
    input logic           rd_en,
    input logic           empty,
    input logic           full,
    input logic [NUM-1:0] wtok_vec,
    input logic [NUM-1:0] rtok_vec,
    input logic [NUM-1:0] wxo_vec,
    input logic [NUM-1:0] rxo_vec
);
    // R8
    one_wtok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(wtok_vec) == 1);
    // R8
    one_rtok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(rtok_vec) == 1);
    // R8
    wtok_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wxo_vec == '0) |=> $stable(wtok_vec));
    // R8
    rtok_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rxo_vec == '0) |=> $stable(rtok_vec));
    // R10
    wpulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(wxo_vec) <= 1);
    // R10
    rpulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(rxo_vec) <= 1);
    // R10
    wpulse_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (NUM > 1 && wxo_vec != '0) |=> (wtok_vec != $past(wtok_vec)));
    // R4
    full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_en && !rd_en) |=> full);
    // R5
    empty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && rd_en && !wr_en) |=> empty);
endmodule

bind xpn_fifo_ring xpn_ring_checker #(.NUM(NUM_SLICES)) u_ring_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .empty(empty), .full(full),
    .wtok_vec(wtok_vec), .rtok_vec(rtok_vec),
    .wxo_vec(wxo_vec), .rxo_vec(rxo_vec)
);

// File: tb/tb_xpn_fifo_ring.sv
`timescale 1ns/1ps
module tb_xpn_fifo_ring;
    localparam int NS  = 3;
    localparam int SD  = 4;
    localparam int DW  = 8;
    localparam int CAP = NS * SD;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic rd_en = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_data;
    logic empty, full;

    int checks = 0;
    int errors = 0;
    string tag = "R1";
    logic [DW-1:0] model_q [$];
    logic [DW-1:0] seq = 8'd1;
    int written = 0;
    logic [15:0] lfsr = 16'hACE1;

    always #5 clk = ~clk;

    xpn_fifo_ring #(.NUM_SLICES(NS), .SLICE_DEPTH(SD), .DATA_W(DW)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .empty(empty), .full(full)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Behavioural reference: a queue of capacity CAP
    always @(posedge clk) begin
        if (!rst_n) model_q.delete();
        else begin
            automatic int n = model_q.size();
            automatic bit racc = rd_en && (n > 0);
            automatic bit wacc = wr_en && (n < CAP);
            if (racc) void'(model_q.pop_front());
            if (wacc) begin
                model_q.push_back(wr_data);
                written++;
            end
        end
    end

    // Compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            chk(empty == (model_q.size() == 0), tag, "empty", empty, model_q.size() == 0);
            chk(full == (model_q.size() == CAP), tag, "full", full, model_q.size() == CAP);
            if (model_q.size() > 0)
                chk(rd_data == model_q[0], {tag, "/R2/R9"}, "rd_data", rd_data, model_q[0]);
        end
    end

    task automatic cyc(input bit we, input bit re);
        wr_en = we;
        rd_en = re;
        if (we) begin
            wr_data = seq;
            seq = seq + 8'd1;
        end
        @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        tag = "R1";
        chk(empty == 1'b1, "R1", "empty after reset", empty, 1);
        chk(full == 1'b0, "R1", "full after reset", full, 0);

        // R5: reads on empty are ignored
        tag = "R5";
        cyc(0, 1); cyc(0, 1);
        chk(empty == 1'b1, "R5", "empty after idle reads", empty, 1);

        // R3: fill to capacity
        tag = "R3";
        for (int i = 0; i < CAP - 1; i++) cyc(1, 0);
        chk(full == 1'b0, "R3", "full one short of capacity", full, 0);
        cyc(1, 0);
        chk(full == 1'b1, "R3", "full at capacity", full, 1);

        // R4: writes on full are ignored
        tag = "R4";
        cyc(1, 0); cyc(1, 0); cyc(1, 0);
        chk(full == 1'b1, "R4", "full held", full, 1);
        chk(rd_data == 8'd1, "R4", "head unchanged", rd_data, 1);

        // R2: drain part across a slice boundary
        tag = "R2";
        for (int i = 0; i < 5; i++) cyc(0, 1);

        // R6 / R7: simultaneous traffic, several laps
        tag = "R6";
        for (int i = 0; i < 10; i++) cyc(1, 1);
        tag = "R7";
        for (int i = 0; i < 3 * CAP; i++) cyc(1, 1);
        chk(written > 2 * CAP, "R7", "words through ring", written, 2 * CAP + 1);

        // R5: full drain then extra reads
        tag = "R5";
        for (int i = 0; i < CAP + 3; i++) cyc(0, 1);
        chk(empty == 1'b1, "R5", "empty after drain", empty, 1);

        // R8 / R10: pseudo-random mix through the boundaries
        tag = "R8";
        for (int i = 0; i < 400; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (i < 200) cyc(lfsr[0] | lfsr[1], lfsr[2] & lfsr[3]);
            else         cyc(lfsr[0] & lfsr[1], lfsr[2] | lfsr[3]);
        end
        tag = "R10";
        for (int i = 0; i < 2 * CAP; i++) cyc(1, i[0]);
        for (int i = 0; i < 3 * CAP; i++) cyc(0, 1);

        wr_en = 1'b0;
        rd_en = 1'b0;
        @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule